// File: doc/BRIEF.md
# Real-time counter interrupt flag register

This block collects the three event sources of a real-time counter running in 32-bit count mode into one 8-bit flag register. The sources are a counter overflow, a match against compare slot 0, and the end of a register synchronization. Each event sets a sticky flag. Software clears a flag by writing a one to its bit. Beside the flags the block keeps an interrupt-enable mask, and it drives one registered interrupt request line.

A write to one address turns enable bits on. A write to another address turns them off. Both of these addresses read back the current mask. The synchronization-ready flag reports only ordinary synchronizations. The block records what started each busy period at the moment busy rises. It then suppresses the flag when that period was an enable or a software reset.

Top module: `rtc_irq_flags`

## Requirements
- R1: After a synchronous reset the flag register reads 0x00, the enable mask reads 0x00 and `irq` is low.
- R2: The flag register is at bus address 2. Overflow is bit 7, synchronization-ready is bit 6 and compare-0 is bit 0. The enable mask uses the same bit positions.
- R3: Bits 5 to 1 of the flag register and of the enable mask always read zero and ignore writes. Bus address 3 reads 0x00.
- R4: A write to address 2 clears every flag whose data bit is one and leaves every flag whose data bit is zero unchanged.
- R5: A one-cycle `ovf_pulse` sets the overflow flag at the next rising clock edge.
- R6: A one-cycle `cmp_pulse` sets the compare-0 flag at the next rising clock edge.
- R7: When `sync_busy` falls from 1 to 0 and the busy period had cause 0 (other), the synchronization-ready flag is set at the edge that samples busy low.
- R8: No synchronization-ready flag is set when the busy period had cause 1 (enable) or cause 2 (software reset). The cause is captured only in the cycle busy rises, so later changes of `sync_cause` during the busy period have no effect.
- R9: When a hardware set and a software clear of the same flag occur in the same cycle, the flag ends up set.
- R10: A write to address 1 sets the enable bits whose data bit is one. A write to address 0 clears them. Both addresses read the current mask.
- R11: `irq` is high in a cycle exactly when, in the previous cycle, some flag and its enable bit were both one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_pulse | input | 1 | Overflow event from the counter |
| cmp_pulse | input | 1 | Compare-0 match event from the counter |
| sync_busy | input | 1 | Synchronization busy status |
| sync_cause | input | 2 | Cause of a starting busy period: 0 other, 1 enable, 2 software reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Registered interrupt request |

## Verification
The flag logic is driven with isolated overflow and compare pulses, and with writes that carry ones and zeros in different bit positions. These separate a clear from an untouched bit and show the reserved bits are inert. Busy periods are run with each of the three causes, including a cause that changes while busy is high. This tells apart cause capture on the rising edge from sampling on the falling edge. Events that coincide with a clear of the same flag test set-over-clear priority. Enable writes at both mask addresses, combined with set flags, show the one-cycle lag of the request line.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 2;
    localparam int NUM_SRC = 3;

    localparam int SRC_CMP  = 0;
    localparam int SRC_SYNC = 1;
    localparam int SRC_OVF  = 2;

    typedef enum logic [1:0] {
        CAUSE_OTHER  = 2'd0,
        CAUSE_ENABLE = 2'd1,
        CAUSE_SWRST  = 2'd2
    } sync_cause_e;

    typedef enum logic [ADDR_W-1:0] {
        ADR_EN_CLR = 2'd0,
        ADR_EN_SET = 2'd1,
        ADR_FLAGS  = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic               wr_flags;
        logic               wr_en_set;
        logic               wr_en_clr;
        logic [NUM_SRC-1:0] bits;
    } bus_cmd_t;

    function automatic int src_bit(input int idx);
        case (idx)
            SRC_CMP:  return 0;
            SRC_SYNC: return 6;
            default:  return 7;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] expand(input logic [NUM_SRC-1:0] v);
        logic [REG_W-1:0] w;
        w = '0;
        for (int i = 0; i < NUM_SRC; i++) w[src_bit(i)] = v[i];
        return w;
    endfunction

    function automatic logic [NUM_SRC-1:0] compress(input logic [REG_W-1:0] w);
        logic [NUM_SRC-1:0] v;
        for (int i = 0; i < NUM_SRC; i++) v[i] = w[src_bit(i)];
        return v;
    endfunction
endpackage

// File: rtl/rtc_sync_track.sv
module rtc_sync_track
    import rtc_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        busy_i,
    input  sync_cause_e cause_i,
    output logic        ready_o
);
    logic        busy_q;
    sync_cause_e cause_q;
    logic        rise, fall;

    assign rise    = busy_i & ~busy_q;
    assign fall    = ~busy_i & busy_q;
    assign ready_o = fall & (cause_q == CAUSE_OTHER);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cause_q <= CAUSE_OTHER;
        end else begin
            busy_q <= busy_i;
            if (rise) cause_q <= cause_i;
        end
    end

    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && busy_i) |=> $stable(cause_q)); // R8
endmodule

// File: rtl/rtc_flag_bits.sv
module rtc_flag_bits #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= set_i[g] | (q & ~clr_i[g]);
        end
        assign flags_o[g] = q;

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> q); // R9
        AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
            (q && !clr_i[g]) |=> q); // R4
    end
endmodule

// File: rtl/rtc_irq_enable.sv
module rtc_irq_enable #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] mask_o
);
    logic [N-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= (mask_q | set_i) & ~clr_i;
    end
    assign mask_o = mask_q;

    AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0 && clr_i == '0) |=> ((mask_o & $past(set_i)) == $past(set_i))); // R10
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ovf_pulse,
    input  logic              cmp_pulse,
    input  logic              sync_busy,
    input  logic [1:0]        sync_cause,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);
    bus_cmd_t           cmd;
    logic [NUM_SRC-1:0] hw_set, flag_clr, flags, mask, en_set, en_clr;
    logic               sync_ready;
    logic               irq_q;

    always_comb begin
        cmd           = '0;
        cmd.bits      = compress(bus_wdata);
        cmd.wr_flags  = bus_sel & bus_wr & (bus_addr == ADR_FLAGS);
        cmd.wr_en_set = bus_sel & bus_wr & (bus_addr == ADR_EN_SET);
        cmd.wr_en_clr = bus_sel & bus_wr & (bus_addr == ADR_EN_CLR);
    end

    rtc_sync_track u_sync (
        .clk     (clk),
        .rst     (rst),
        .busy_i  (sync_busy),
        .cause_i (sync_cause_e'(sync_cause)),
        .ready_o (sync_ready)
    );

    always_comb begin
        hw_set           = '0;
        hw_set[SRC_OVF]  = ovf_pulse;
        hw_set[SRC_CMP]  = cmp_pulse;
        hw_set[SRC_SYNC] = sync_ready;
    end

    assign flag_clr = cmd.wr_flags  ? cmd.bits : '0;
    assign en_set   = cmd.wr_en_set ? cmd.bits : '0;
    assign en_clr   = cmd.wr_en_clr ? cmd.bits : '0;

    rtc_flag_bits #(.N(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (hw_set),
        .clr_i   (flag_clr),
        .flags_o (flags)
    );

    rtc_irq_enable #(.N(NUM_SRC)) u_enable (
        .clk    (clk),
        .rst    (rst),
        .set_i  (en_set),
        .clr_i  (en_clr),
        .mask_o (mask)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(flags & mask);
    end
    assign irq = irq_q;

    always_comb begin
        case (bus_addr)
            ADR_FLAGS:              bus_rdata = expand(flags);
            ADR_EN_SET, ADR_EN_CLR: bus_rdata = expand(mask);
            default:                bus_rdata = '0;
        endcase
    end

    logic ast_ok;
    always_ff @(posedge clk) ast_ok <= !rst;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[5:1] == 5'd0); // R3
    AST_OVF_SETS: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |=> flags[SRC_OVF]); // R5
    AST_CMP_SETS: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |=> flags[SRC_CMP]); // R6
    AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_flags && bus_wdata[7] && !ovf_pulse) |=> !flags[SRC_OVF]); // R4
    AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (rst || !ast_ok)
        ast_ok |=> (irq == $past(|(flags & mask)))); // R11
endmodule

// File: tb/rtc_irq_flags_bench.sv
`timescale 1ns/1ps
module rtc_irq_flags_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ovf_pulse = 0, cmp_pulse = 0, sync_busy = 0;
    logic [1:0] sync_cause = 0;
    logic       bus_sel = 0, bus_wr = 0;
    logic [1:0] bus_addr = 2'd2;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       irq;

    int  n_run = 0, n_fail = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    rtc_irq_flags u_rtc_irq_flags (.*);

    // behavioural reference model
    logic [7:0] m_flags = 0, m_en = 0;
    logic       m_busy = 0, m_irq = 0;
    logic [1:0] m_cause = 0;
    always @(posedge clk) begin
        logic [7:0] setv, clrv;
        if (rst) begin
            m_flags = 0; m_en = 0; m_busy = 0; m_cause = 0; m_irq = 0;
        end else begin
            m_irq = (m_flags & m_en) != 0;
            setv = 0;
            if (ovf_pulse) setv[7] = 1;
            if (cmp_pulse) setv[0] = 1;
            if (m_busy && !sync_busy && m_cause == 0) setv[6] = 1;
            if (!m_busy && sync_busy) m_cause = sync_cause;
            m_busy = sync_busy;
            clrv = (bus_sel && bus_wr && bus_addr == 2) ? (bus_wdata & 8'hC1) : 8'h00;
            m_flags = setv | (m_flags & ~clrv);
            if (bus_sel && bus_wr && bus_addr == 1) m_en = m_en | (bus_wdata & 8'hC1);
            if (bus_sel && bus_wr && bus_addr == 0) m_en = m_en & ~(bus_wdata & 8'hC1);
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [7:0] exp_rd;
            exp_rd = (bus_addr == 2) ? m_flags : (bus_addr == 3) ? 8'h00 : m_en;
            check({7'd0, irq}, {7'd0, m_irq}, "R11 irq");
            if (bus_addr == 2)      check(bus_rdata, exp_rd, "R2 flags read");
            else if (bus_addr == 3) check(bus_rdata, exp_rd, "R3 unused addr");
            else                    check(bus_rdata, exp_rd, "R10 mask read");
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 0; bus_wr = 0; bus_addr = 2;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; #1;
        check(bus_rdata, exp, tag);
        bus_addr = 2;
    endtask

    task automatic busy_run(input logic [1:0] cause, input logic [1:0] late_cause, input int len);
        sync_busy = 1; sync_cause = cause; tick();
        sync_cause = late_cause;
        repeat (len) tick();
        sync_busy = 0; tick();
        sync_cause = 0;
    endtask

    initial begin
        #800000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) tick();
        rst = 0; tick();
        rd(2, 8'h00, "R1 flags after reset");
        rd(1, 8'h00, "R1 mask after reset");
        check({7'd0, irq}, 8'h00, "R1 irq after reset");

        ovf_pulse = 1; tick(); ovf_pulse = 0;
        rd(2, 8'h80, "R5 overflow flag");
        wr(2, 8'h7F);
        rd(2, 8'h80, "R4 zero leaves flag / R3 reserved write");
        wr(2, 8'h80);
        rd(2, 8'h00, "R4 one clears flag");

        cmp_pulse = 1; tick(); cmp_pulse = 0;
        rd(2, 8'h01, "R6 compare flag");

        busy_run(2'd0, 2'd0, 3);
        rd(2, 8'h41, "R7 sync ready set");
        wr(2, 8'hFF);
        rd(2, 8'h00, "R4 clear all");

        busy_run(2'd1, 2'd0, 3);
        rd(2, 8'h00, "R8 enable cause suppressed");
        busy_run(2'd2, 2'd0, 2);
        rd(2, 8'h00, "R8 swreset cause suppressed");
        busy_run(2'd0, 2'd1, 2);
        rd(2, 8'h40, "R8 late cause ignored");

        wr(1, 8'hFF);
        rd(1, 8'hC1, "R10 set mask / R3 reserved");
        rd(0, 8'hC1, "R10 mask at clear address");
        rd(3, 8'h00, "R3 unused address");
        tick();
        check({7'd0, irq}, 8'h01, "R11 irq with sync flag enabled");
        wr(0, 8'h40);
        rd(1, 8'h81, "R10 clear mask bit");
        tick(); tick();
        check({7'd0, irq}, 8'h00, "R11 irq low after disable");

        bus_sel = 1; bus_wr = 1; bus_addr = 2; bus_wdata = 8'h80; ovf_pulse = 1;
        tick();
        bus_sel = 0; bus_wr = 0; ovf_pulse = 0;
        rd(2, 8'hC0, "R9 set beats clear");
        tick();
        check({7'd0, irq}, 8'h01, "R11 irq on overflow");

        wr(2, 8'hC1);
        sync_busy = 1; tick(); sync_busy = 0; tick(); sync_busy = 1; tick(); sync_busy = 0; tick();
        rd(2, 8'h40, "R7 back-to-back short busy");
        repeat (3) tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule